// File: doc/BRIEF.md
# Polynomial Schoolbook Squarer

This block squares a wide unsigned integer. The operand is a vector of equal-width coefficients, and the block returns the full double-width square. It uses the schoolbook method on the coefficients. Every partial-product bit is the AND of two operand bits. Because the operation is a square, each pair of distinct bits is generated only once and given double weight by a one-bit left shift. Each bit's product with itself reduces to the bit itself and goes in at its natural weight.

The partial-product rows enter a tree of 3:2 carry-save compressors. The tree leaves a redundant sum/carry pair, and a carry-propagate adder merges that pair into the binary result. A parameter selects the adder style. Another parameter places a single register stage on the output. With the register in place, a product appears one clock after its operand is presented, and the block accepts one operand per clock. Modular reduction is left to a later stage.

Top module: `poly_squarer`

## Requirements
- R1: With in_valid high, out_product one cycle later equals the square of in_operand, taken as an unsigned integer of NUM_COEF*COEF_W bits. Coefficient c occupies operand bits [c*COEF_W +: COEF_W].
- R2: out_valid is high in the cycle after a clock edge at which in_valid was high, and low in the cycle after an edge at which in_valid was low.
- R3: While in_valid is low, out_product holds its value, and in_operand has no effect on it.
- R4: A synchronous active-high reset clears out_valid and out_product to zero. Reset takes priority over an in_valid that is high in the same cycle.
- R5: A zero operand gives a zero product.
- R6: An all-ones operand gives 2^(2W) - 2^(W+1) + 1, where W = NUM_COEF*COEF_W.
- R7: An operand with only bit k set gives a product with only bit 2k set.
- R8: Operands presented on consecutive cycles produce their products on consecutive cycles, in the same order.
- R9: Product bit 0 equals operand bit 0, and product bit 1 is always zero.
- R10: The product never exceeds (2^W - 1)^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand is valid this cycle |
| in_operand | input | NUM_COEF*COEF_W | Operand, coefficient 0 in the least significant bits |
| out_valid | output | 1 | Product is valid |
| out_product | output | 2*NUM_COEF*COEF_W | Square of the last accepted operand |

## Verification
Two things can fall in the same cycle. In one case, a new operand is captured while the previous product is on the output: the bench presents operands back to back and checks that each product appears in order, one cycle after its own operand. In the other case, reset and in_valid are both high: the bench raises them together and expects a cleared output, which shows that reset wins. The arithmetic is judged against a square computed in the bench at double width. The operands cover zero, all ones, every single-bit value, and a series of pseudo-random values.

// File: rtl/squarer_pkg.sv
package squarer_pkg;

    localparam int DEF_NUM_COEF = 4;
    localparam int DEF_COEF_W   = 8;

    typedef enum logic {
        CPA_RIPPLE = 1'b0,
        CPA_NATIVE = 1'b1
    } cpa_kind_e;

    // number of distinct coefficient pairs (i < j)
    function automatic int pair_count(input int n);
        return n * (n - 1) / 2;
    endfunction

    // lower coefficient index of the k-th distinct pair
    function automatic int pair_lo(input int k, input int n);
        int idx;
        idx = 0;
        for (int i = 0; i < n; i++) begin
            for (int j = i + 1; j < n; j++) begin
                if (idx == k) return i;
                idx++;
            end
        end
        return 0;
    endfunction

    // upper coefficient index of the k-th distinct pair
    function automatic int pair_hi(input int k, input int n);
        int idx;
        idx = 0;
        for (int i = 0; i < n; i++) begin
            for (int j = i + 1; j < n; j++) begin
                if (idx == k) return j;
                idx++;
            end
        end
        return 0;
    endfunction

    // rows left after one level of 3:2 compression
    function automatic int csa_next(input int n);
        return 2 * (n / 3) + (n % 3);
    endfunction

    // total partial-product rows for a given geometry
    function automatic int row_count(input int n, input int w);
        return pair_count(n) * w + w;
    endfunction

endpackage

// File: rtl/squarer_ppgen.sv
module squarer_ppgen
    import squarer_pkg::*;
#(
    parameter int NUM_COEF = DEF_NUM_COEF,
    parameter int COEF_W   = DEF_COEF_W
) (
    input  logic [NUM_COEF*COEF_W-1:0]   operand_i,
    output logic [2*NUM_COEF*COEF_W-1:0] rows_o [row_count(NUM_COEF, COEF_W)]
);
    localparam int OPW   = NUM_COEF * COEF_W;
    localparam int PRW   = 2 * OPW;
    localparam int NPAIR = pair_count(NUM_COEF);

    // Cross terms: coefficient pair (i<j), bit p of a_i times a_j,
    // placed at (i+j)*COEF_W + p and doubled by one extra shift.
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int LO = pair_lo(k, NUM_COEF);
        localparam int HI = pair_hi(k, NUM_COEF);
        logic [COEF_W-1:0] c_lo;
        logic [COEF_W-1:0] c_hi;
        assign c_lo = operand_i[LO*COEF_W +: COEF_W];
        assign c_hi = operand_i[HI*COEF_W +: COEF_W];
        for (genvar p = 0; p < COEF_W; p++) begin : g_bit
            assign rows_o[k*COEF_W + p] =
                {{(PRW-COEF_W){1'b0}}, c_hi & {COEF_W{c_lo[p]}}}
                    << ((LO + HI) * COEF_W + p + 1);
        end
    end

    // Diagonal terms: square of each coefficient, itself symmetric.
    // Row p gathers bit p of every coefficient; segments never overlap.
    for (genvar p = 0; p < COEF_W; p++) begin : g_diag
        logic [PRW-1:0] drow;
        for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
            logic [COEF_W-1:0]   ci;
            logic [2*COEF_W-1:0] seg;
            assign ci  = operand_i[i*COEF_W +: COEF_W];
            assign seg = ({{COEF_W{1'b0}}, (ci >> (p + 1)) & {COEF_W{ci[p]}}}
                             << (2 * p + 2))
                       | ({{(2*COEF_W-1){1'b0}}, ci[p]} << (2 * p));
            assign drow[i*2*COEF_W +: 2*COEF_W] = seg;
        end
        assign rows_o[NPAIR*COEF_W + p] = drow;
    end

endmodule

// File: rtl/squarer_csa3.sv
module squarer_csa3 #(
    parameter int PW = 64
) (
    input  logic [PW-1:0] a_i,
    input  logic [PW-1:0] b_i,
    input  logic [PW-1:0] c_i,
    output logic [PW-1:0] sum_o,
    output logic [PW-1:0] carry_o
);
    // Bitwise full-adder row; the carry of the top column is beyond the
    // product width and the true sum never reaches it.
    assign sum_o   = a_i ^ b_i ^ c_i;
    assign carry_o = {(a_i[PW-2:0] & b_i[PW-2:0])
                    | (a_i[PW-2:0] & c_i[PW-2:0])
                    | (b_i[PW-2:0] & c_i[PW-2:0]), 1'b0};
endmodule

// File: rtl/squarer_csa_tree.sv
module squarer_csa_tree
    import squarer_pkg::*;
#(
    parameter int N  = 3,
    parameter int PW = 64
) (
    input  logic [PW-1:0] rows_i [N],
    output logic [PW-1:0] sum_o,
    output logic [PW-1:0] carry_o
);
    if (N == 1) begin : g_one
        assign sum_o   = rows_i[0];
        assign carry_o = '0;
    end else if (N == 2) begin : g_two
        assign sum_o   = rows_i[0];
        assign carry_o = rows_i[1];
    end else begin : g_level
        localparam int GRP = N / 3;
        localparam int REM = N % 3;
        localparam int NXT = csa_next(N);
        logic [PW-1:0] nxt [NXT];

        for (genvar g = 0; g < GRP; g++) begin : g_cell
            squarer_csa3 #(.PW(PW)) u_csa (
                .a_i    (rows_i[3*g]),
                .b_i    (rows_i[3*g+1]),
                .c_i    (rows_i[3*g+2]),
                .sum_o  (nxt[2*g]),
                .carry_o(nxt[2*g+1])
            );
        end
        for (genvar r = 0; r < REM; r++) begin : g_pass
            assign nxt[2*GRP + r] = rows_i[3*GRP + r];
        end

        squarer_csa_tree #(.N(NXT), .PW(PW)) u_sub (
            .rows_i (nxt),
            .sum_o  (sum_o),
            .carry_o(carry_o)
        );
    end
endmodule

// File: rtl/squarer_cpa.sv
module squarer_cpa
    import squarer_pkg::*;
#(
    parameter int        PW   = 64,
    parameter cpa_kind_e KIND = CPA_RIPPLE
) (
    input  logic [PW-1:0] sum_i,
    input  logic [PW-1:0] carry_i,
    output logic [PW-1:0] result_o
);
    if (KIND == CPA_RIPPLE) begin : g_ripple
        logic [PW-1:0] cy;
        assign cy[0] = 1'b0;
        for (genvar b = 0; b < PW; b++) begin : g_bit
            assign result_o[b] = sum_i[b] ^ carry_i[b] ^ cy[b];
            if (b < PW - 1) begin : g_cy
                assign cy[b+1] = (sum_i[b] & carry_i[b])
                               | (sum_i[b] & cy[b])
                               | (carry_i[b] & cy[b]);
            end
        end
    end else begin : g_native
        assign result_o = sum_i + carry_i;
    end
endmodule

// File: rtl/poly_squarer.sv
module poly_squarer
    import squarer_pkg::*;
#(
    parameter int        NUM_COEF = DEF_NUM_COEF,
    parameter int        COEF_W   = DEF_COEF_W,
    parameter bit        OUT_REG  = 1'b1,
    parameter cpa_kind_e CPA_KIND = CPA_RIPPLE
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic [NUM_COEF*COEF_W-1:0]     in_operand,
    output logic                           out_valid,
    output logic [2*NUM_COEF*COEF_W-1:0]   out_product
);
    localparam int PRW  = 2 * NUM_COEF * COEF_W;
    localparam int NROW = row_count(NUM_COEF, COEF_W);

    logic [PRW-1:0] pp_rows [NROW];
    logic [PRW-1:0] red_sum;
    logic [PRW-1:0] red_carry;
    logic [PRW-1:0] square;

    squarer_ppgen #(.NUM_COEF(NUM_COEF), .COEF_W(COEF_W)) u_ppgen (
        .operand_i(in_operand),
        .rows_o   (pp_rows)
    );

    squarer_csa_tree #(.N(NROW), .PW(PRW)) u_tree (
        .rows_i (pp_rows),
        .sum_o  (red_sum),
        .carry_o(red_carry)
    );

    squarer_cpa #(.PW(PRW), .KIND(CPA_KIND)) u_cpa (
        .sum_i   (red_sum),
        .carry_i (red_carry),
        .result_o(square)
    );

    if (OUT_REG) begin : g_reg
        logic           vld_q;
        logic [PRW-1:0] prod_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                prod_q <= '0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) prod_q <= square;
            end
        end
        assign out_valid   = vld_q;
        assign out_product = prod_q;
    end else begin : g_comb
        assign out_valid   = in_valid;
        assign out_product = square;
    end
endmodule

// File: rtl/squarer_checker.sv
module squarer_checker #(
    parameter int NUM_COEF = 4,
    parameter int COEF_W   = 8,
    parameter bit OUT_REG  = 1'b1
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic [NUM_COEF*COEF_W-1:0]    in_operand,
    input logic                          out_valid,
    input logic [2*NUM_COEF*COEF_W-1:0]  out_product
);
    localparam int OPW = NUM_COEF * COEF_W;
    localparam int PRW = 2 * OPW;
    localparam logic [PRW-1:0] MAX_SQ =
        {{OPW{1'b0}}, {OPW{1'b1}}} * {{OPW{1'b0}}, {OPW{1'b1}}};

    if (OUT_REG) begin : g_seq
        // R2
        a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        // R3
        a_r3_hold: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(out_product));
        // R5
        a_r5_zero: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_operand == '0) |=> (out_product == '0));
        // R9
        a_r9_lsb: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_product[0] == $past(in_operand[0])));
        a_r9_bit1: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_product[1] == 1'b0));
        // R10
        a_r10_bound: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_product <= MAX_SQ));
    end
endmodule

bind poly_squarer squarer_checker #(
    .NUM_COEF(NUM_COEF),
    .COEF_W  (COEF_W),
    .OUT_REG (OUT_REG)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_product(out_product)
);

// File: tb/tb_poly_squarer.sv
module tb_poly_squarer;
    localparam int NC  = 4;
    localparam int CW  = 8;
    localparam int OPW = NC * CW;
    localparam int PRW = 2 * OPW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [OPW-1:0] in_operand = '0;
    logic           out_valid;
    logic [PRW-1:0] out_product;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    poly_squarer #(.NUM_COEF(NC), .COEF_W(CW)) dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_product(out_product)
    );

    function automatic logic [PRW-1:0] ref_sq(input logic [OPW-1:0] a);
        logic [PRW-1:0] w;
        w = {{OPW{1'b0}}, a};
        return w * w;
    endfunction

    task automatic check(input string req, input logic [PRW-1:0] act,
                         input logic [PRW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one operand, product checked one cycle later
    task automatic apply_one(input string req, input logic [OPW-1:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_operand = a;
        @(negedge clk);
        in_valid = 1'b0; in_operand = ~a;
        check(req, out_product, ref_sq(a));
        check({req, " valid"}, {{(PRW-1){1'b0}}, out_valid}, 1);
    endtask

    task automatic t_reset_state;
        check("R4 reset valid", {{(PRW-1){1'b0}}, out_valid}, 0);
        check("R4 reset product", out_product, '0);
    endtask

    task automatic t_corners;
        logic [PRW-1:0] all1;
        all1 = ({{(PRW-1){1'b0}}, 1'b1} << PRW-1) * 2
             - ({{(PRW-1){1'b0}}, 1'b1} << (OPW + 1)) + 1;
        apply_one("R5 zero", '0);
        check("R5 zero product", out_product, '0);
        apply_one("R6 all ones", '1);
        check("R6 closed form", out_product, all1);
        for (int k = 0; k < OPW; k++) begin
            apply_one("R7 single bit", {{(OPW-1){1'b0}}, 1'b1} << k);
            check("R7 only bit 2k", out_product,
                  {{(PRW-1){1'b0}}, 1'b1} << (2 * k));
        end
    endtask

    task automatic t_coeff_patterns;
        for (int c = 0; c < NC; c++) begin
            apply_one("R1 one coefficient full",
                      {{(OPW-CW){1'b0}}, {CW{1'b1}}} << (c * CW));
        end
        apply_one("R1 alternating", {(OPW/2){2'b10}});
        apply_one("R1 coefficient borders", 32'h80018001);
    endtask

    task automatic t_random;
        logic [OPW-1:0] a;
        for (int n = 0; n < 200; n++) begin
            a = $urandom;
            apply_one("R1 random", a);
            check("R9 low bits", {{(PRW-2){1'b0}}, out_product[1:0]},
                  {{(PRW-1){1'b0}}, a[0]});
            checks++;
            if (out_product > ref_sq('1)) begin
                errors++;
                $display("FAIL R10: actual %h expected <= %h",
                         out_product, ref_sq('1));
            end
        end
    endtask

    task automatic t_back_to_back;
        logic [OPW-1:0] ops [4];
        ops[0] = 32'h12345678; ops[1] = 32'hFFFF0000;
        ops[2] = 32'h0000FFFF; ops[3] = 32'hDEADBEEF;
        @(negedge clk);
        in_valid = 1'b1; in_operand = ops[0];
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            check("R8 in order", out_product, ref_sq(ops[i-1]));
            in_operand = ops[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 last", out_product, ref_sq(ops[3]));
        check("R2 valid high", {{(PRW-1){1'b0}}, out_valid}, 1);
        @(negedge clk);
        check("R2 valid low", {{(PRW-1){1'b0}}, out_valid}, 0);
    endtask

    task automatic t_hold;
        logic [PRW-1:0] keep;
        apply_one("R3 load", 32'hA5A5_3C3C);
        keep = out_product;
        for (int i = 0; i < 4; i++) begin
            in_operand = $urandom;
            @(negedge clk);
            check("R3 hold", out_product, keep);
            check("R3 valid low", {{(PRW-1){1'b0}}, out_valid}, 0);
        end
    endtask

    task automatic t_reset_priority;
        apply_one("R4 preload", 32'h7777_1111);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_operand = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R4 priority valid", {{(PRW-1){1'b0}}, out_valid}, 0);
        check("R4 priority product", out_product, '0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_corners();
        t_coeff_patterns();
        t_back_to_back();
        t_hold();
        t_random();
        t_reset_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule